// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synchronous on-chip memory that takes one command on every rising clock edge. Reads and writes may be mixed in any order with no idle cycle between them. Every input is captured at the edge. A read returns its word two edges later. A write takes its data two edges after the command, so both kinds of operation use the same data-bus slot and the bus never has to turn around.

The word is split into byte lanes of nine bits. Each lane has its own active-low write enable. A read of a word whose write has not yet reached the array gets the pending lanes forwarded. The block is selected only when three chip enables are all asserted.

A load/advance control either takes a fresh external address or steps the internal address of the running burst. The step counts linearly and wraps inside an aligned group of four words. Each word of read data is marked by a valid flag and by an echo strobe that changes level for that word. The depth is a parameter; the full-size organisation uses an 18-bit address.

Top module: `zbtSram`

## Requirements
- R1: Commands are captured on the rising clock edge. The data and valid flag of a read change at the second rising edge after the edge that captured the read command.
- R2: For a write command captured at edge t, the write data bus is sampled at edge t+2. The values on the bus at other edges do not affect that write.
- R3: A read may follow a write in the very next cycle, to the same address or another one, and a write may follow a read, with no idle cycle. Every read returns the word as it stands after all earlier write commands, lane by lane.
- R4: On a load cycle with the device selected, rwN low issues a write and rwN high issues a read.
- R5: Lane i covers data bits [9i+8:9i]. A write changes only the lanes whose byteWrN bit is low; the other lanes keep their contents. All bits low writes the whole 72-bit word.
- R6: The device is selected only when ceN=0, ceA=1 and ceB=1. A load cycle that is not selected performs no operation: rdValid stays low for it and memory is unchanged.
- R7: advance=0 loads addrIn; advance=1 continues the running burst. A burst continues the last loaded operation at the previous address with its two low bits incremented modulo 4 and its upper bits unchanged. On advance cycles rwN and the chip enables are ignored, while byteWrN is sampled.
- R8: An advance cycle after reset, or after a deselected load cycle, performs no operation.
- R9: echoClk changes level at each edge that loads a valid read word, and holds its level at every other edge.
- R10: After reset, rdValid is low, echoClk is low and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are captured on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| addrIn | input | ADDR_W | External word address, used on load cycles |
| advance | input | 1 | 1 = step the running burst, 0 = load addrIn |
| rwN | input | 1 | Operation select on load cycles: 0 = write, 1 = read |
| byteWrN | input | LANES | Active-low per-lane write enables |
| ceN | input | 1 | Active-low chip enable |
| ceA | input | 1 | Active-high chip enable |
| ceB | input | 1 | Active-high chip enable |
| wrData | input | LANES*LANE_W | Write data, sampled two edges after its command |
| rdData | output | LANES*LANE_W | Registered read data |
| rdValid | output | 1 | High while rdData holds the word of a read |
| echoClk | output | 1 | Strobe that changes level with each valid read word |

## Verification
The hardest case to reach from the ports is a read that hits a word whose write data was captured at the previous edge but has not yet been committed to the array. Only some lanes of that pending write are enabled, so the read must merge forwarded lanes with stored ones. It occurs only when a partial-lane write is followed in the very next cycle by a read of the same address. A directed task issues exactly that pair, both alone and inside alternating write/read runs and write bursts that wrap. A random mix over a small address space then produces many more such collisions, and every read is compared with a reference array that is updated in command order.

// File: rtl/zbtSramPkg.sv
package zbtSramPkg;

  // Kind of operation carried through the command pipeline
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } opKind_e;

  // Strobes from the control pipeline to the datapath
  typedef struct packed {
    logic rdFire;   // read the array at this edge into the output register
    logic wrFire;   // capture write data at this edge into the pending slot
  } strobe_t;

  // Number of low address bits that a burst steps through
  localparam int unsigned BURST_BITS = 2;

endpackage

// File: rtl/zbtSramBurst.sv
module zbtSramBurst
  import zbtSramPkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              advance,
  input  logic              selIn,
  input  logic              wrReq,
  output opKind_e           curOp,
  output logic [ADDR_W-1:0] curAddr
);

  localparam int unsigned HI_W = ADDR_W - BURST_BITS;

  opKind_e           burstOp;
  logic [ADDR_W-1:0] burstAddr;
  logic [BURST_BITS-1:0] stepLow;

  assign stepLow = burstAddr[BURST_BITS-1:0] + 1'b1;

  always_comb begin
    if (advance) begin
      curOp   = burstOp;
      curAddr = {burstAddr[ADDR_W-1 -: HI_W], stepLow};
    end else begin
      curAddr = addrIn;
      if (!selIn)     curOp = OP_NONE;
      else if (wrReq) curOp = OP_WRITE;
      else            curOp = OP_READ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstOp   <= OP_NONE;
      burstAddr <= '0;
    end else begin
      burstOp   <= curOp;
      burstAddr <= curAddr;
    end
  end

endmodule

// File: rtl/zbtSramCtrl.sv
module zbtSramCtrl
  import zbtSramPkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              advance,
  input  logic              rwN,
  input  logic [LANES-1:0]  byteWrN,
  input  logic              ceN,
  input  logic              ceA,
  input  logic              ceB,
  output strobe_t           strb,
  output logic [ADDR_W-1:0] opAddr,
  output logic [LANES-1:0]  opLanes
);

  logic              selected;
  opKind_e           curOp;
  logic [ADDR_W-1:0] curAddr;

  opKind_e           s1Op, s2Op;
  logic [ADDR_W-1:0] s1Addr, s2Addr;
  logic [LANES-1:0]  s1Lanes, s2Lanes;

  assign selected = !ceN && ceA && ceB;

  zbtSramBurst #(.ADDR_W(ADDR_W)) uBurst (
    .clk     (clk),
    .rstN    (rstN),
    .addrIn  (addrIn),
    .advance (advance),
    .selIn   (selected),
    .wrReq   (!rwN),
    .curOp   (curOp),
    .curAddr (curAddr)
  );

  // Two registered stages: capture edge, then one stage of alignment
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Op    <= OP_NONE;
      s1Addr  <= '0;
      s1Lanes <= '0;
      s2Op    <= OP_NONE;
      s2Addr  <= '0;
      s2Lanes <= '0;
    end else begin
      s1Op    <= curOp;
      s1Addr  <= curAddr;
      s1Lanes <= ~byteWrN;
      s2Op    <= s1Op;
      s2Addr  <= s1Addr;
      s2Lanes <= s1Lanes;
    end
  end

  assign strb.rdFire = (s2Op == OP_READ);
  assign strb.wrFire = (s2Op == OP_WRITE);
  assign opAddr      = s2Addr;
  assign opLanes     = s2Lanes;

  AST_DESEL_NOP: assert property (@(posedge clk) disable iff (!rstN)
    (!advance && !selected) |=> (s1Op == OP_NONE)); // R6

  AST_LOAD_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (!advance && selected && !rwN) |=> (s1Op == OP_WRITE)); // R4

  AST_LOAD_READ: assert property (@(posedge clk) disable iff (!rstN)
    (!advance && selected && rwN) |=> (s1Op == OP_READ)); // R4

  AST_ADV_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (advance && s1Op == OP_NONE) |=> (s1Op == OP_NONE)); // R8

  AST_BURST_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (advance && s1Op != OP_NONE) |=>
      (s1Addr[ADDR_W-1:BURST_BITS] == $past(s1Addr[ADDR_W-1:BURST_BITS]) &&
       s1Addr[BURST_BITS-1:0] == $past(s1Addr[BURST_BITS-1:0]) + 1'b1 &&
       s1Op == $past(s1Op))); // R7

endmodule

// File: rtl/zbtSramData.sv
module zbtSramData
  import zbtSramPkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 8,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned DATA_W = LANES * LANE_W,
  localparam int unsigned DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [LANES-1:0]  opLanes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              echoClk
);

  // Single pending write: data captured, commit to the array one edge later
  logic              pendValid;
  logic [ADDR_W-1:0] pendAddr;
  logic [LANES-1:0]  pendLanes;
  logic [DATA_W-1:0] pendData;

  logic              hit;
  logic [DATA_W-1:0] merged;

  assign hit = pendValid && (pendAddr == opAddr);

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] store [DEPTH];
    logic [LANE_W-1:0] fromStore;

    always_ff @(posedge clk) begin
      if (pendValid && pendLanes[g])
        store[pendAddr] <= pendData[g*LANE_W +: LANE_W];
    end

    assign fromStore = store[opAddr];
    assign merged[g*LANE_W +: LANE_W] =
      (hit && pendLanes[g]) ? pendData[g*LANE_W +: LANE_W] : fromStore;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendAddr  <= '0;
      pendLanes <= '0;
      pendData  <= '0;
    end else begin
      pendValid <= strb.wrFire;
      if (strb.wrFire) begin
        pendAddr  <= opAddr;
        pendLanes <= opLanes;
        pendData  <= wrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
      echoClk <= 1'b0;
    end else begin
      rdValid <= strb.rdFire;
      if (strb.rdFire) begin
        rdData  <= merged;
        echoClk <= ~echoClk;
      end
    end
  end

  AST_RD_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdFire |=> rdValid); // R1

  AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdFire |=> !rdValid); // R6

  AST_WR_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrFire |=> (pendValid && pendData == $past(wrData))); // R2

  AST_ECHO_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (echoClk != $past(echoClk))); // R9

  AST_ECHO_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> $stable(echoClk)); // R9

endmodule

// File: rtl/zbtSram.sv
module zbtSram
  import zbtSramPkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 8,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              advance,
  input  logic              rwN,
  input  logic [LANES-1:0]  byteWrN,
  input  logic              ceN,
  input  logic              ceA,
  input  logic              ceB,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              echoClk
);

  strobe_t           strb;
  logic [ADDR_W-1:0] opAddr;
  logic [LANES-1:0]  opLanes;

  zbtSramCtrl #(.ADDR_W(ADDR_W), .LANES(LANES)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .addrIn  (addrIn),
    .advance (advance),
    .rwN     (rwN),
    .byteWrN (byteWrN),
    .ceN     (ceN),
    .ceA     (ceA),
    .ceB     (ceB),
    .strb    (strb),
    .opAddr  (opAddr),
    .opLanes (opLanes)
  );

  zbtSramData #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .opAddr  (opAddr),
    .opLanes (opLanes),
    .wrData  (wrData),
    .rdData  (rdData),
    .rdValid (rdValid),
    .echoClk (echoClk)
  );

  AST_SINGLE_OP: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.rdFire && strb.wrFire)); // R4

endmodule

// File: tb/test_zbtSram.sv
`timescale 1ns/1ps
module test_zbtSram;

  localparam int AW    = 6;
  localparam int NL    = 8;
  localparam int LW    = 9;
  localparam int DW    = NL * LW;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic          advance = 1'b0;
  logic          rwN = 1'b1;
  logic [NL-1:0] byteWrN = '1;
  logic          ceN = 1'b1, ceA = 1'b0, ceB = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic          rdValid;
  logic          echoClk;

  always #2 clk = ~clk;

  zbtSram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) i_zbtSram (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .advance(advance), .rwN(rwN),
    .byteWrN(byteWrN), .ceN(ceN), .ceA(ceA), .ceB(ceB), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid), .echoClk(echoClk)
  );

  int checks = 0;
  int fails  = 0;

  // Reference model
  logic [DW-1:0] mMem [WORDS];
  int            mOp = 0;            // 0 none, 1 read, 2 write
  logic [AW-1:0] mAddr = '0;
  logic [DW-1:0] dQ [2];
  logic          eV [3];
  logic [DW-1:0] eD [3];
  string         eT [3];
  logic          expEcho = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic checkOut();
    check(rdValid == eV[2], eT[2], "rdValid", DW'(rdValid), DW'(eV[2]));
    if (eV[2]) begin
      expEcho = ~expEcho;
      check(rdData == eD[2], eT[2], "rdData", rdData, eD[2]);
    end
    check(echoClk == expEcho, "R9", "echoClk", DW'(echoClk), DW'(expEcho));
  endtask

  // One command per cycle; ce = {ceN, ceA, ceB}
  task automatic step(input logic adv, input logic [2:0] ce, input logic isWr,
                      input logic [AW-1:0] a, input logic [NL-1:0] beN,
                      input logic [DW-1:0] d, input string tag);
    int            op;
    logic [AW-1:0] ea;
    checkOut();
    if (adv) begin
      op = mOp;
      ea = {mAddr[AW-1:2], mAddr[1:0] + 2'd1};
    end else begin
      ea = a;
      if (ce == 3'b011) op = isWr ? 2 : 1;
      else              op = 0;
    end
    mOp = op;
    mAddr = ea;
    eV[2] = eV[1]; eD[2] = eD[1]; eT[2] = eT[1];
    eV[1] = eV[0]; eD[1] = eD[0]; eT[1] = eT[0];
    eV[0] = (op == 1);
    eD[0] = (op == 1) ? mMem[ea] : '0;
    eT[0] = tag;
    if (op == 2) begin
      for (int l = 0; l < NL; l++)
        if (!beN[l]) mMem[ea][l*LW +: LW] = d[l*LW +: LW];
    end
    advance = adv;
    {ceN, ceA, ceB} = ce;
    rwN = !isWr;
    addrIn = a;
    byteWrN = beN;
    wrData = dQ[1];
    dQ[1] = dQ[0];
    dQ[0] = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [DW-1:0] rnd();
    logic [DW-1:0] v;
    for (int l = 0; l < NL; l++) v[l*LW +: LW] = LW'($urandom);
    return v;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 3'b111, 1'b0, '0, '1, rnd(), "R6");
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    step(1'b0, 3'b011, 1'b0, a, '1, rnd(), tag);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [NL-1:0] beN,
                    input logic [DW-1:0] d, input string tag);
    step(1'b0, 3'b011, 1'b1, a, beN, d, tag);
  endtask

  task automatic t_reset();
    check(rdValid == 1'b0, "R10", "rdValid after reset", DW'(rdValid), '0);
    check(echoClk == 1'b0, "R10", "echoClk after reset", DW'(echoClk), '0);
    // R8: advance straight after reset is no operation
    step(1'b1, 3'b011, 1'b0, '0, '1, rnd(), "R8");
    step(1'b1, 3'b011, 1'b0, '0, '1, rnd(), "R8");
    idle(3);
  endtask

  task automatic t_fill();
    // R4 / R1: full-word writes everywhere, then a paced read-back
    for (int i = 0; i < WORDS; i++) wr(AW'(i), '0, rnd(), "R4");
    for (int i = 0; i < WORDS; i += 7) begin
      rd(AW'(i), "R1");
      idle(2);
    end
    idle(3);
  endtask

  task automatic t_lanes();
    wr(6'd5, 8'h00, rnd(), "R5");
    idle(3);
    wr(6'd5, 8'b1010_1010, rnd(), "R5");
    idle(3);
    rd(6'd5, "R5");
    wr(6'd5, 8'b0111_1111, rnd(), "R5");
    idle(3);
    rd(6'd5, "R5");
    idle(3);
  endtask

  task automatic t_backToBack();
    // R3: read right behind a partial write of the same word (bypass merge)
    wr(6'd9, 8'h0F, rnd(), "R3");
    rd(6'd9, "R3");
    wr(6'd9, 8'hF0, rnd(), "R3");
    rd(6'd9, "R3");
    wr(6'd10, 8'h00, rnd(), "R3");
    rd(6'd9, "R3");
    rd(6'd10, "R3");
    wr(6'd10, 8'h3C, rnd(), "R3");
    wr(6'd10, 8'hC3, rnd(), "R3");
    rd(6'd10, "R3");
    // R2: lone write framed by reads that put other data on the bus
    rd(6'd11, "R2");
    wr(6'd11, 8'h00, rnd(), "R2");
    rd(6'd12, "R2");
    rd(6'd13, "R2");
    rd(6'd11, "R2");
    idle(3);
  endtask

  task automatic t_burst();
    // R7: write burst from addr 6 wraps 6,7,4,5; rwN and enables ignored
    wr(6'd6, 8'h00, rnd(), "R7");
    step(1'b1, 3'b111, 1'b0, 6'd40, 8'h00, rnd(), "R7");
    step(1'b1, 3'b100, 1'b0, 6'd41, 8'h55, rnd(), "R7");
    step(1'b1, 3'b011, 1'b0, 6'd42, 8'h00, rnd(), "R7");
    rd(6'd6, "R7");
    step(1'b1, 3'b111, 1'b1, 6'd0, '1, rnd(), "R7");
    step(1'b1, 3'b011, 1'b1, 6'd0, '1, rnd(), "R7");
    step(1'b1, 3'b001, 1'b1, 6'd0, '1, rnd(), "R7");
    step(1'b1, 3'b011, 1'b1, 6'd0, '1, rnd(), "R7");
    rd(6'd40, "R7");
    rd(6'd41, "R7");
    idle(3);
  endtask

  task automatic t_desel();
    // R6: a write issued with any enable off changes nothing
    step(1'b0, 3'b111, 1'b1, 6'd12, 8'h00, rnd(), "R6");
    step(1'b0, 3'b001, 1'b1, 6'd12, 8'h00, rnd(), "R6");
    step(1'b0, 3'b010, 1'b1, 6'd12, 8'h00, rnd(), "R6");
    // R8: advance after a deselected load is no operation
    step(1'b1, 3'b011, 1'b1, 6'd12, 8'h00, rnd(), "R8");
    idle(2);
    rd(6'd12, "R6");
    rd(6'd13, "R6");
    step(1'b0, 3'b111, 1'b0, 6'd12, '1, rnd(), "R6");
    step(1'b1, 3'b011, 1'b0, 6'd12, '1, rnd(), "R8");
    idle(3);
  endtask

  task automatic t_random();
    for (int i = 0; i < 600; i++) begin
      logic          adv;
      logic [2:0]    ce;
      logic [NL-1:0] beN;
      adv = ($urandom % 4) == 0;
      ce  = (($urandom % 8) == 0) ? 3'($urandom % 7 + 1) : 3'b011;
      if (ce == 3'b011) ce = 3'b111;
      if (($urandom % 8) != 0) ce = 3'b011;
      beN = (($urandom % 4) == 0) ? '0 : NL'($urandom);
      step(adv, ce, 1'($urandom), AW'($urandom % 16), beN, rnd(), "R3");
    end
    idle(3);
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    dQ[0] = '0; dQ[1] = '0;
    for (int i = 0; i < 3; i++) begin eV[i] = 1'b0; eD[i] = '0; eT[i] = "R10"; end
    for (int i = 0; i < WORDS; i++) mMem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_lanes();
    t_backToBack();
    t_burst();
    t_desel();
    t_random();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule